// File: doc/BRIEF.md
# Shared GPIO and ADC Input Port Controller

This block manages a small input port in which every pin can serve either as a plain digital input or as an input to an analog-to-digital converter. A per-bit function-select register decides the role of each pin. Port reads pass pad levels through a mask, so a pin assigned to the converter, or any pin while the chip is in clock-stop mode, reads as zero.

A separate channel-select register names the pin to convert. A conversion-start command captures that channel and sends a one-cycle start pulse to the converter. The block then waits for the converter's done strobe and raises a completion flag. The converter itself is outside the block and is seen only as a start/done handshake. The command decoder that drives the write and start inputs is also outside the block.

Top module: `sharedInPort`

## Requirements
- R1: After reset, every function-select bit is 0 (digital input), so a port read returns the pad levels. The flags `convBusy` and `convDone` are 0, `adcStart` is 0 and `adcChan` is 0.
- R2: A write with `fnWrEn` loads `fnWrData` into the function-select register on the next clock edge. In that register, bit i = 1 puts pin i in converter use and bit i = 0 keeps it as a digital input. From then on, read bit i is 0 for every converter-use pin and equals `pinIn[i]` for every digital-input pin.
- R3: While `clkStop` is 1, `portRdData` is all zeros, whatever the pad levels and the function selects are.
- R4: A write with `chWrEn` loads `chWrData` into the channel-select register. When a conversion starts, `adcChan` takes the channel-select value that was held in the cycle `convStart` was sampled.
- R5: When `convStart` is sampled while idle, `adcStart` is 1 for exactly one cycle, starting at the next clock edge. `convBusy` goes to 1 at that same edge.
- R6: When `adcDone` is sampled while busy, `convDone` becomes 1 and `convBusy` becomes 0 at the next clock edge. `convDone` stays 1 until a new conversion starts.
- R7: A conversion start clears `convDone` at the same edge where `convBusy` rises.
- R8: A `convStart` sampled while busy is ignored. It produces no `adcStart` pulse, and `adcChan` does not change. This also holds when `adcDone` arrives in the same cycle.
- R9: While busy, `adcChan` stays stable even if the channel-select register is rewritten.
- R10: An `adcDone` sampled while idle has no effect on `convDone` or `convBusy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Pad input levels |
| clkStop | input | 1 | Clock-stop mode active; all read paths disabled |
| fnWrEn | input | 1 | Write strobe for the function-select register |
| fnWrData | input | NUM_PINS | Function-select value, 1 = converter use |
| chWrEn | input | 1 | Write strobe for the channel-select register |
| chWrData | input | CH_W | Channel number to convert |
| convStart | input | 1 | Conversion-start command bit |
| adcDone | input | 1 | Converter done strobe |
| portRdData | output | NUM_PINS | Masked port read data |
| adcStart | output | 1 | One-cycle start pulse to the converter |
| adcChan | output | CH_W | Channel held for the running conversion |
| convBusy | output | 1 | Conversion in progress |
| convDone | output | 1 | Conversion-complete flag |

## Verification
Two events can fall in the same cycle: a fresh start request and the converter's done strobe. The bench drives `convStart` and `adcDone` together while a conversion is running. It then expects the done strobe to win: `convDone` rises, `convBusy` falls, no `adcStart` pulse appears and `adcChan` keeps the old channel. A second collision rewrites the channel register while busy. The bench checks that the captured channel only moves at the next accepted start.

// File: rtl/sharedInPortPkg.sv
package sharedInPortPkg;

  // Strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // accepted start: latch channel select
    logic busy;     // conversion in flight
  } ctlStrobes_t;

endpackage

// File: rtl/sharedInPortCtl.sv
module sharedInPortCtl
  import sharedInPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        convStart,
  input  logic        adcDone,
  output logic        adcStart,
  output logic        convBusy,
  output logic        convDone,
  output ctlStrobes_t strobes
);

  logic busyQ;
  logic doneQ;
  logic startQ;
  logic startOk;

  assign startOk = convStart && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= startOk;
      if (startOk) begin
        busyQ <= 1'b1;
        doneQ <= 1'b0;
      end else if (busyQ && adcDone) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  assign adcStart        = startQ;
  assign convBusy        = busyQ;
  assign convDone        = doneQ;
  assign strobes.capture = startOk;
  assign strobes.busy    = busyQ;

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> convBusy);

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && adcDone) |=> (convDone && !convBusy));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> !convDone);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |=> !adcStart);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!convBusy && !convStart) |=> ($stable(convDone) && !convBusy));

endmodule

// File: rtl/sharedInPortDp.sv
module sharedInPortDp
  import sharedInPortPkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int CH_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                clkStop,
  input  logic                fnWrEn,
  input  logic [NUM_PINS-1:0] fnWrData,
  input  logic                chWrEn,
  input  logic [CH_W-1:0]     chWrData,
  input  ctlStrobes_t         strobes,
  output logic [NUM_PINS-1:0] portRdData,
  output logic [CH_W-1:0]     adcChan
);

  logic [NUM_PINS-1:0] fnSel;
  logic [CH_W-1:0]     chSel;
  logic [CH_W-1:0]     chActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fnSel    <= '0;
      chSel    <= '0;
      chActive <= '0;
    end else begin
      if (fnWrEn)          fnSel    <= fnWrData;
      if (chWrEn)          chSel    <= chWrData;
      if (strobes.capture) chActive <= chSel;
    end
  end

  // Per-pin read gate: digital-input role and no clock stop
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_rdGate
    always_comb portRdData[i] = pinIn[i] && !fnSel[i] && !clkStop;
  end

  assign adcChan = chActive;

  // R2
  adc_pin_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portRdData & fnSel) == '0);

  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && $past(strobes.busy)) |-> $stable(adcChan));

endmodule

// File: rtl/sharedInPort.sv
module sharedInPort
  import sharedInPortPkg::*;
#(
  parameter  int NUM_PINS = 6,
  localparam int CH_W     = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                clkStop,
  input  logic                fnWrEn,
  input  logic [NUM_PINS-1:0] fnWrData,
  input  logic                chWrEn,
  input  logic [CH_W-1:0]     chWrData,
  input  logic                convStart,
  input  logic                adcDone,
  output logic [NUM_PINS-1:0] portRdData,
  output logic                adcStart,
  output logic [CH_W-1:0]     adcChan,
  output logic                convBusy,
  output logic                convDone
);

  ctlStrobes_t strobes;

  sharedInPortCtl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .convStart (convStart),
    .adcDone   (adcDone),
    .adcStart  (adcStart),
    .convBusy  (convBusy),
    .convDone  (convDone),
    .strobes   (strobes)
  );

  sharedInPortDp #(.NUM_PINS(NUM_PINS), .CH_W(CH_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .clkStop    (clkStop),
    .fnWrEn     (fnWrEn),
    .fnWrData   (fnWrData),
    .chWrEn     (chWrEn),
    .chWrData   (chWrData),
    .strobes    (strobes),
    .portRdData (portRdData),
    .adcChan    (adcChan)
  );

  // R3
  stop_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkStop |-> (portRdData == '0));

endmodule

// File: tb/sharedInPort_tb_top.sv
module sharedInPort_tb_top;

  localparam int NUM_PINS = 6;
  localparam int CH_W     = $clog2(NUM_PINS);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NUM_PINS-1:0] pinIn = '0;
  logic                clkStop = 1'b0;
  logic                fnWrEn = 1'b0;
  logic [NUM_PINS-1:0] fnWrData = '0;
  logic                chWrEn = 1'b0;
  logic [CH_W-1:0]     chWrData = '0;
  logic                convStart = 1'b0;
  logic                adcDone = 1'b0;
  logic [NUM_PINS-1:0] portRdData;
  logic                adcStart;
  logic [CH_W-1:0]     adcChan;
  logic                convBusy;
  logic                convDone;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sharedInPort #(.NUM_PINS(NUM_PINS)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .clkStop(clkStop),
    .fnWrEn(fnWrEn), .fnWrData(fnWrData), .chWrEn(chWrEn), .chWrData(chWrData),
    .convStart(convStart), .adcDone(adcDone), .portRdData(portRdData),
    .adcStart(adcStart), .adcChan(adcChan), .convBusy(convBusy), .convDone(convDone)
  );

  // Vector: {fnSel, pins, clkStop, expected read}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {6'h00, 6'h2D, 1'b0, 6'h2D},
    {6'h3F, 6'h3F, 1'b0, 6'h00},
    {6'h15, 6'h3F, 1'b0, 6'h2A},
    {6'h2A, 6'h3F, 1'b0, 6'h15},
    {6'h0F, 6'h33, 1'b0, 6'h30},
    {6'h00, 6'h3F, 1'b1, 6'h00},
    {6'h01, 6'h06, 1'b0, 6'h06},
    {6'h20, 6'h3F, 1'b0, 6'h1F}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge; inputs and samples sit 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    step();
    step();
    rstN = 1'b1;
    pinIn = 6'h3F;
    #0;
    // R1 reset state
    check("R1 read", int'(portRdData), 6'h3F);
    check("R1 busy", int'(convBusy), 0);
    check("R1 done", int'(convDone), 0);
    check("R1 start", int'(adcStart), 0);
    check("R1 chan", int'(adcChan), 0);

    // R10 done strobe while idle before any conversion
    adcDone = 1'b1;
    step();
    adcDone = 1'b0;
    check("R10 done idle", int'(convDone), 0);
    check("R10 busy idle", int'(convBusy), 0);

    // R2 / R3 vector table
    for (int k = 0; k < NV; k++) begin
      fnWrEn = 1'b1;
      fnWrData = VEC[k][18:13];
      step();
      fnWrEn = 1'b0;
      pinIn = VEC[k][12:7];
      clkStop = VEC[k][6];
      #1;
      check(VEC[k][6] ? "R3 stop read" : "R2 masked read",
            int'(portRdData), int'(VEC[k][5:0]));
    end
    clkStop = 1'b0;

    // R4 / R5 start with channel 5
    chWrEn = 1'b1; chWrData = 3'd5;
    step();
    chWrEn = 1'b0;
    convStart = 1'b1;
    step();
    convStart = 1'b0;
    check("R5 pulse", int'(adcStart), 1);
    check("R5 busy", int'(convBusy), 1);
    check("R4 chan", int'(adcChan), 5);

    // R9 rewrite channel while busy
    chWrEn = 1'b1; chWrData = 3'd2;
    step();
    chWrEn = 1'b0;
    check("R5 one cycle", int'(adcStart), 0);
    check("R9 chan held", int'(adcChan), 5);

    // R8 start while busy
    convStart = 1'b1;
    step();
    convStart = 1'b0;
    check("R8 no pulse", int'(adcStart), 0);
    check("R8 chan", int'(adcChan), 5);
    check("R8 still busy", int'(convBusy), 1);

    // R6 completion
    adcDone = 1'b1;
    step();
    adcDone = 1'b0;
    check("R6 done", int'(convDone), 1);
    check("R6 idle", int'(convBusy), 0);
    step();
    step();
    check("R6 done held", int'(convDone), 1);

    // R10 done strobe while idle with flag set
    adcDone = 1'b1;
    step();
    adcDone = 1'b0;
    check("R10 busy", int'(convBusy), 0);
    check("R10 flag", int'(convDone), 1);
    check("R10 no pulse", int'(adcStart), 0);

    // R7 new start clears flag, captures new channel
    convStart = 1'b1;
    step();
    convStart = 1'b0;
    check("R7 cleared", int'(convDone), 0);
    check("R4 new chan", int'(adcChan), 2);
    check("R5 pulse again", int'(adcStart), 1);
    step();

    // R8 start and done in the same cycle while busy
    chWrEn = 1'b1; chWrData = 3'd4;
    convStart = 1'b1;
    adcDone = 1'b1;
    step();
    chWrEn = 1'b0; convStart = 1'b0; adcDone = 1'b0;
    check("R8 collide done", int'(convDone), 1);
    check("R8 collide idle", int'(convBusy), 0);
    check("R8 collide pulse", int'(adcStart), 0);
    check("R8 collide chan", int'(adcChan), 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule